// File: doc/BRIEF.md
# Sticky Reference Counter with Hardware Free List

This block keeps a reference count for every node of a small heap, along with a list of nodes that are not in use. Other memory banks send it count transactions on a dedicated port. Each transaction carries a node address and one bit that picks increment or decrement. A processor talks to the block through a four-address register port. Reading either of two addresses allocates a node and returns its address; one address gives an atomic node and the other gives a binary node. Writing a node address to either of the other two addresses injects an increment or a decrement for that node.

Counts saturate. Once a count reaches its ceiling it stays there for good, so an overflowed node is never freed by counting. When a decrement takes a count from one to zero, the node goes back to the head of the free list without any processor work. The count field of a free node stores the link to the next free node, so the list needs no extra storage. An allocation attempt that finds the list empty returns zero (NIL). It also sets a flag that stays set, which higher levels use to request a full collection.

Top module: `sticky_refcount_heap`

## Requirements
- R1: After reset, every node reports kind free (code 0) with count 0, the exhausted flag is low, and allocations hand out nodes 1, 2, 3 and so on in ascending order. Node 0 is NIL and is never handed out.
- R2: An accepted read with regSel 0 allocates an atomic node (kind code 1). An accepted read with regSel 1 allocates a binary node (kind code 2). The new node's address appears on regRdata with regRvalid high in the cycle after acceptance, and its count starts at 1.
- R3: An increment raises a live node's count by one only while the count is below the ceiling 2^CNT_W-1. At the ceiling, the count stays put.
- R4: A decrement to a node whose count equals the ceiling leaves the count unchanged.
- R5: A decrement that takes a count from 1 to 0 marks the node free. The node becomes the head of the free list, so the next allocation returns it (last freed, first reused).
- R6: An accepted write with regSel 2 increments the node named on regWdata. An accepted write with regSel 3 decrements that node.
- R7: An allocation with the free list empty returns 0 with regRvalid high and sets poolEmpty. poolEmpty stays high until reset, even after nodes are freed again.
- R8: When txnValid is high, regReady is low and a register request in that cycle is not accepted. The count transaction is applied on its own.
- R9: A count transaction that names address 0 or a node that is currently free has no effect.
- R10: Writes with regSel 0 or 1 and reads with regSel 2 or 3 have no effect and produce no regRvalid.
- R11: Each accepted count transaction is applied in full before the next one, one per cycle. Its result shows on the peek port one cycle after acceptance, so back-to-back transactions to one node accumulate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txnValid | input | 1 | Count transaction present |
| txnDec | input | 1 | 1 = decrement, 0 = increment |
| txnAddr | input | ADDR_W | Target node of the count transaction |
| regValid | input | 1 | Register request present |
| regWrite | input | 1 | 1 = write, 0 = read |
| regSel | input | 2 | 0 alloc atomic, 1 alloc binary, 2 inject increment, 3 inject decrement |
| regWdata | input | ADDR_W | Node address for inject writes |
| regReady | output | 1 | Register request accepted this cycle |
| regRdata | output | ADDR_W | Allocated node address (0 when exhausted) |
| regRvalid | output | 1 | regRdata valid |
| poolEmpty | output | 1 | Sticky free-list exhausted flag |
| peekAddr | input | ADDR_W | Node to observe |
| peekCount | output | CNT_W | Count of the observed node (0 when free) |
| peekKind | output | 2 | Kind of the observed node: 0 free, 1 atomic, 2 binary |

## Verification
An allocation read and a count transaction can arrive in the same cycle, and only the count transaction may proceed. The bench drives both at once, with the count aimed at a live node and the register request set to allocate or to inject. It then expects regReady to be low, no read data in the following cycle, the count change visible on the peek port, and the free-list order unchanged. A reference model built from queues and integer arrays is compared with the outputs on every clock. Pseudo-random traffic then mixes collisions, frees and exhaustion.

// File: rtl/rc_heap_pkg.sv
package rc_heap_pkg;

  typedef enum logic [1:0] {
    KIND_FREE = 2'd0,
    KIND_ATOM = 2'd1,
    KIND_BIN  = 2'd2
  } nodeKind_t;

  // strobes from control to datapath; doCount and doAlloc are never both set
  typedef struct packed {
    logic doCount;
    logic cntDec;
    logic doAlloc;
    logic allocBin;
  } ctrlStrobe_t;

endpackage

// File: rtl/rc_heap_ctrl.sv
module rc_heap_ctrl
  import rc_heap_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txnValid,
  input  logic              txnDec,
  input  logic [ADDR_W-1:0] txnAddr,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [1:0]        regSel,
  input  logic [ADDR_W-1:0] regWdata,
  output logic              regReady,
  output ctrlStrobe_t       strobe,
  output logic [ADDR_W-1:0] opAddr
);

  logic regTake;
  logic regInject;

  // the count port wins every collision
  assign regReady  = ~txnValid;
  assign regTake   = regValid & regReady;
  assign regInject = regTake & regWrite & regSel[1];

  always_comb begin
    strobe          = '0;
    strobe.doCount  = txnValid | regInject;
    strobe.cntDec   = txnValid ? txnDec : regSel[0];
    strobe.doAlloc  = regTake & ~regWrite & ~regSel[1];
    strobe.allocBin = regSel[0];
  end

  assign opAddr = txnValid ? txnAddr : regWdata;

  a_r8_count_first: assert property (@(posedge clk) disable iff (!rstN)
    txnValid |-> (!strobe.doAlloc && !regReady && strobe.cntDec == txnDec));

  a_r10_misdirected_write: assert property (@(posedge clk) disable iff (!rstN)
    (regValid && regWrite && !regSel[1]) |-> (!strobe.doAlloc && strobe.doCount == txnValid));

  a_r10_misdirected_read: assert property (@(posedge clk) disable iff (!rstN)
    (regValid && !regWrite && regSel[1]) |-> !strobe.doAlloc);

endmodule

// File: rtl/rc_heap_datapath.sv
module rc_heap_datapath
  import rc_heap_pkg::*;
#(
  parameter int NODES  = 16,
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [ADDR_W-1:0] opAddr,
  input  logic [ADDR_W-1:0] peekAddr,
  output logic [ADDR_W-1:0] regRdata,
  output logic              regRvalid,
  output logic              poolEmpty,
  output logic [CNT_W-1:0]  peekCount,
  output logic [1:0]        peekKind
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [CNT_W-1:0] STICKY = '1;
  localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

  // count field of a live node; link to next free node otherwise
  logic [CNT_W-1:0] cntMem  [DEPTH];
  nodeKind_t        kindMem [DEPTH];
  logic [ADDR_W-1:0] headQ;

  logic              opLive;
  logic [CNT_W-1:0]  opCnt;
  logic              atSticky;
  logic              listEmpty;
  logic [ADDR_W-1:0] headLink;

  always_comb begin
    opCnt     = cntMem[opAddr];
    opLive    = (opAddr != '0) && (kindMem[opAddr] != KIND_FREE);
    atSticky  = (opCnt == STICKY);
    listEmpty = (headQ == '0);
    headLink  = cntMem[headQ][ADDR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        kindMem[i] <= KIND_FREE;
        cntMem[i]  <= (i > 0 && i < NODES - 1) ? CNT_W'(i + 1) : '0;
      end
      headQ     <= ADDR_W'(NODES > 1 ? 1 : 0);
      poolEmpty <= 1'b0;
      regRvalid <= 1'b0;
      regRdata  <= '0;
    end else begin
      regRvalid <= strobe.doAlloc;
      if (strobe.doCount && opLive && !atSticky) begin
        if (!strobe.cntDec) begin
          cntMem[opAddr] <= opCnt + ONE;
        end else if (opCnt == ONE) begin
          cntMem[opAddr]  <= CNT_W'(headQ);
          kindMem[opAddr] <= KIND_FREE;
          headQ           <= opAddr;
        end else begin
          cntMem[opAddr] <= opCnt - ONE;
        end
      end
      if (strobe.doAlloc) begin
        if (!listEmpty) begin
          regRdata       <= headQ;
          headQ          <= headLink;
          cntMem[headQ]  <= ONE;
          kindMem[headQ] <= strobe.allocBin ? KIND_BIN : KIND_ATOM;
        end else begin
          regRdata  <= '0;
          poolEmpty <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    peekKind  = kindMem[peekAddr];
    peekCount = (kindMem[peekAddr] == KIND_FREE) ? '0 : cntMem[peekAddr];
  end

  a_r3_r4_sticky_hold: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.doCount && opLive && atSticky) |=> (cntMem[$past(opAddr)] == STICKY));

  a_r7_empty_stays: assert property (@(posedge clk) disable iff (!rstN)
    poolEmpty |=> poolEmpty);

  a_r5_head_is_free: assert property (@(posedge clk) disable iff (!rstN)
    (headQ != '0) |-> (kindMem[headQ] == KIND_FREE));

  a_r2_alloc_live: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.doAlloc && !listEmpty) |=> (regRdata != '0 && kindMem[regRdata] != KIND_FREE
                                        && cntMem[regRdata] == ONE));

  a_r7_empty_nil: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.doAlloc && listEmpty) |=> (regRdata == '0 && poolEmpty));

endmodule

// File: rtl/sticky_refcount_heap.sv
module sticky_refcount_heap
  import rc_heap_pkg::*;
#(
  parameter int NODES  = 16,
  parameter int CNT_W  = 8,
  parameter int ADDR_W = $clog2(NODES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txnValid,
  input  logic              txnDec,
  input  logic [ADDR_W-1:0] txnAddr,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [1:0]        regSel,
  input  logic [ADDR_W-1:0] regWdata,
  output logic              regReady,
  output logic [ADDR_W-1:0] regRdata,
  output logic              regRvalid,
  output logic              poolEmpty,
  input  logic [ADDR_W-1:0] peekAddr,
  output logic [CNT_W-1:0]  peekCount,
  output logic [1:0]        peekKind
);

  // CNT_W must be at least ADDR_W so a count field can hold a link
  ctrlStrobe_t       strobe;
  logic [ADDR_W-1:0] opAddr;

  rc_heap_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .txnValid(txnValid), .txnDec(txnDec), .txnAddr(txnAddr),
    .regValid(regValid), .regWrite(regWrite), .regSel(regSel), .regWdata(regWdata),
    .regReady(regReady), .strobe(strobe), .opAddr(opAddr)
  );

  rc_heap_datapath #(.NODES(NODES), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .opAddr(opAddr), .peekAddr(peekAddr),
    .regRdata(regRdata), .regRvalid(regRvalid), .poolEmpty(poolEmpty),
    .peekCount(peekCount), .peekKind(peekKind)
  );

endmodule

// File: tb/sticky_refcount_heap_tb_top.sv
`timescale 1ns/1ps
module sticky_refcount_heap_tb_top;

  localparam int NODES  = 8;
  localparam int CNT_W  = 4;
  localparam int ADDR_W = 3;
  localparam int STICKY = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txnValid = 1'b0, txnDec = 1'b0;
  logic [ADDR_W-1:0] txnAddr = '0;
  logic regValid = 1'b0, regWrite = 1'b0;
  logic [1:0] regSel = '0;
  logic [ADDR_W-1:0] regWdata = '0;
  logic regReady, regRvalid, poolEmpty;
  logic [ADDR_W-1:0] regRdata;
  logic [ADDR_W-1:0] peekAddr = '0;
  logic [CNT_W-1:0] peekCount;
  logic [1:0] peekKind;

  always #10 clk = ~clk;

  sticky_refcount_heap #(.NODES(NODES), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rstN(rstN), .txnValid(txnValid), .txnDec(txnDec), .txnAddr(txnAddr),
    .regValid(regValid), .regWrite(regWrite), .regSel(regSel), .regWdata(regWdata),
    .regReady(regReady), .regRdata(regRdata), .regRvalid(regRvalid), .poolEmpty(poolEmpty),
    .peekAddr(peekAddr), .peekCount(peekCount), .peekKind(peekKind)
  );

  int nChecks = 0, nFail = 0;
  bit done = 1'b0;
  int mCnt [NODES];
  int mKind [NODES];
  int freeQ [$];
  bit mExh;
  bit expRvalid;
  int expRdata;
  int peekPtr = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic void modelCount(int a, bit dec);
    if (a == 0 || mKind[a] == 0) return;
    if (!dec) begin
      if (mCnt[a] < STICKY) mCnt[a]++;
    end else if (mCnt[a] != STICKY) begin
      mCnt[a]--;
      if (mCnt[a] == 0) begin
        mKind[a] = 0;
        freeQ.push_front(a);
      end
    end
  endfunction

  function automatic void modelStep(bit tv, bit td, int ta, bit rv, bit rw, int rs, int wd);
    expRvalid = 1'b0;
    if (tv) modelCount(ta, td);
    else if (rv) begin
      if (rw && rs >= 2) modelCount(wd, rs == 3);
      else if (!rw && rs < 2) begin
        expRvalid = 1'b1;
        if (freeQ.size() > 0) begin
          expRdata = freeQ.pop_front();
          mKind[expRdata] = rs + 1;
          mCnt[expRdata] = 1;
        end else begin
          expRdata = 0;
          mExh = 1'b1;
        end
      end
    end
  endfunction

  // called at a negedge; returns at the following negedge
  task automatic step(bit tv, bit td, int ta, bit rv, bit rw, int rs, int wd, string tag);
    int pk;
    txnValid = tv; txnDec = td; txnAddr = ADDR_W'(ta);
    regValid = rv; regWrite = rw; regSel = 2'(rs); regWdata = ADDR_W'(wd);
    peekAddr = ADDR_W'(peekPtr);
    peekPtr = (peekPtr + 1) % NODES;
    #1;
    pk = int'(peekAddr);
    chk(regReady == !tv, {tag, " R8 regReady"}, regReady, !tv);
    chk(int'(peekKind) == mKind[pk], {tag, " peekKind"}, peekKind, mKind[pk]);
    chk(int'(peekCount) == (mKind[pk] == 0 ? 0 : mCnt[pk]), {tag, " peekCount"},
        peekCount, mKind[pk] == 0 ? 0 : mCnt[pk]);
    @(posedge clk);
    modelStep(tv, td, ta, rv, rw, rs, wd);
    @(negedge clk);
    txnValid = 1'b0; regValid = 1'b0;
    chk(poolEmpty == mExh, {tag, " poolEmpty"}, poolEmpty, mExh);
    chk(regRvalid == expRvalid, {tag, " regRvalid"}, regRvalid, expRvalid);
    if (expRvalid) chk(int'(regRdata) == expRdata, {tag, " regRdata"}, regRdata, expRdata);
  endtask

  task automatic peekExpect(int a, int c, int k, string tag);
    peekAddr = ADDR_W'(a);
    #1;
    chk(int'(peekCount) == c, {tag, " literal count"}, peekCount, c);
    chk(int'(peekKind) == k, {tag, " literal kind"}, peekKind, k);
  endtask

  task automatic allocStep(int rs, string tag);
    step(1'b0, 1'b0, 0, 1'b1, 1'b0, rs, 0, tag);
  endtask

  task automatic txnStep(bit dec, int a, string tag);
    step(1'b1, dec, a, 1'b0, 1'b0, 0, 0, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog R11: actual 0 expected 1 (run did not finish)");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NODES; i++) begin mCnt[i] = 0; mKind[i] = 0; end
    for (int i = 1; i < NODES; i++) freeQ.push_back(i);
    mExh = 1'b0; expRvalid = 1'b0; expRdata = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(poolEmpty == 1'b0, "R1 poolEmpty after reset", poolEmpty, 0);
    chk(regRvalid == 1'b0, "R1 regRvalid after reset", regRvalid, 0);
    for (int a = 0; a < NODES; a++) peekExpect(a, 0, 0, "R1");

    // R1/R2 allocation order and kinds
    allocStep(0, "R2 atom");
    chk(int'(regRdata) == 1, "R1 first node", regRdata, 1);
    allocStep(1, "R2 binary");
    chk(int'(regRdata) == 2, "R1 second node", regRdata, 2);
    peekExpect(1, 1, 1, "R2");
    peekExpect(2, 1, 2, "R2");

    // R3 saturation, R4 decrement at ceiling
    for (int i = 0; i < STICKY + 2; i++) txnStep(1'b0, 1, "R3 inc");
    peekExpect(1, STICKY, 1, "R3");
    txnStep(1'b1, 1, "R4 dec at ceiling");
    peekExpect(1, STICKY, 1, "R4");

    // R6 injected inc/dec
    step(1'b0, 1'b0, 0, 1'b1, 1'b1, 2, 2, "R6 inject inc");
    peekExpect(2, 2, 2, "R6");
    step(1'b0, 1'b0, 0, 1'b1, 1'b1, 3, 2, "R6 inject dec");
    peekExpect(2, 1, 2, "R6");

    // R5 free on zero, reused first
    txnStep(1'b1, 2, "R5 dec to zero");
    peekExpect(2, 0, 0, "R5");
    allocStep(0, "R5 realloc");
    chk(int'(regRdata) == 2, "R5 freed node reused", regRdata, 2);

    // R9 NIL and free targets ignored
    txnStep(1'b0, 5, "R9 inc free node");
    txnStep(1'b1, 0, "R9 dec NIL");
    peekExpect(5, 0, 0, "R9");
    peekExpect(0, 0, 0, "R9");
    allocStep(0, "R9 order kept");
    chk(int'(regRdata) == 3, "R9 free list order unchanged", regRdata, 3);

    // R10 misdirected accesses
    step(1'b0, 1'b0, 0, 1'b1, 1'b1, 0, 4, "R10 write alloc addr");
    chk(regRvalid == 1'b0, "R10 no rvalid on write", regRvalid, 0);
    step(1'b0, 1'b0, 0, 1'b1, 1'b0, 2, 0, "R10 read inc addr");
    chk(regRvalid == 1'b0, "R10 no rvalid on read of sel2", regRvalid, 0);
    step(1'b0, 1'b0, 0, 1'b1, 1'b0, 3, 0, "R10 read dec addr");
    allocStep(1, "R10 next alloc");
    chk(int'(regRdata) == 4, "R10 list untouched", regRdata, 4);
    peekExpect(4, 1, 2, "R10");

    // R8 collisions
    step(1'b1, 1'b0, 3, 1'b1, 1'b0, 0, 0, "R8 alloc vs inc");
    chk(regRvalid == 1'b0, "R8 alloc held off", regRvalid, 0);
    peekExpect(3, 2, 1, "R8");
    step(1'b1, 1'b1, 3, 1'b1, 1'b1, 2, 4, "R8 inject vs dec");
    peekExpect(4, 1, 2, "R8");
    peekExpect(3, 1, 1, "R8");

    // R11 back-to-back on one node
    txnStep(1'b0, 4, "R11");
    txnStep(1'b0, 4, "R11");
    peekExpect(4, 3, 2, "R11");
    txnStep(1'b1, 4, "R11");
    txnStep(1'b1, 4, "R11");
    txnStep(1'b1, 4, "R11");
    peekExpect(4, 0, 0, "R11");

    // R7 exhaustion
    for (int i = 0; i < 4; i++) allocStep(0, "R7 drain");
    chk(poolEmpty == 1'b0, "R7 not yet empty", poolEmpty, 0);
    allocStep(1, "R7 empty alloc");
    chk(int'(regRdata) == 0, "R7 NIL returned", regRdata, 0);
    chk(poolEmpty == 1'b1, "R7 flag set", poolEmpty, 1);
    txnStep(1'b1, 3, "R7 free one");
    chk(poolEmpty == 1'b1, "R7 flag sticky", poolEmpty, 1);
    allocStep(0, "R7 realloc");
    chk(int'(regRdata) == 3, "R7 freed node given", regRdata, 3);

    // mixed traffic against the model
    for (int i = 0; i < 400; i++) begin
      int r = int'($urandom);
      step(r[0] & r[1], r[2], (r >> 3) & 7, r[6], r[7] & r[8], (r >> 9) & 3, (r >> 11) & 7,
           "R11 mixed");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule